// File: doc/BRIEF.md
# SMBus Slave Event Matcher

This block is the receiving side of a host controller's SMBus slave port. It watches the bus for write-word transactions from an external master. A transaction whose 7-bit address is either the port's own fixed address or one of up to four shadow addresses is acknowledged byte by byte. On the closing STOP, the block captures the command byte and the 16-bit data word into read-only registers.

Transactions to the port's own address can also raise a wake/interrupt event. All three of the following must hold:
- the captured command equals a programmable compare byte;
- the data word shares at least one set bit with a programmable mask;
- the port is enabled.

Shadow-address transactions are captured but never signal. Software programs the compare byte, the mask and the enable bit, and reads the captured values, through a small synchronous register port.

Top module: `smb_evt_port`

## Requirements
- R1: After reset, every register reads 0000h, `evt_pulse` is 0 and `sda_oe` is 0.
- R2: For a write (R/W bit 0) to the own address (default 10h) or to a shadow address, `sda_oe` holds SDA low during the ninth clock of the address byte and of each of the three following bytes.
- R3: An address byte that matches no address, or that has R/W bit 1, is not acknowledged and leaves the captured values unchanged.
- R4: A completed write to the own address updates the captured command (register 0, bits 7:0) and the data word (register 1). The first data byte becomes bits 7:0 and the second becomes bits 15:8. Bytes arrive MSB first.
- R5: A completed write to a shadow address (defaults 45h and 2Ch) updates the captures in the same way but never raises `evt_pulse`.
- R6: A completed write to the own address gives exactly one `evt_pulse` if the command equals the compare byte, the data word ANDed with the mask is non-zero, and the enable bit is 1. The pulse is one clock wide.
- R7: No event is raised when the command differs from the compare byte.
- R8: No event is raised when the data word ANDed with the mask is zero.
- R9: No event is raised when the enable bit (register 4, bit 0) is 0.
- R10: A transfer that ends with STOP before all three bytes after the address have been acknowledged leaves the captured values unchanged.
- R11: The registers are: 0 captured command (RO), 1 captured data (RO), 2 compare byte (RW, bits 7:0), 3 event mask (RW), 4 enable (RW, bit 0). A write is visible on the read port from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SMBus clock line |
| sda_in | input | 1 | SMBus data line |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| evt_pulse | output | 1 | One-clock wake/interrupt event |

## Verification
Every bus edge reaches the logic three clocks later: two synchroniser flops, then the registered decision. The bench therefore holds each SCL phase for eight clocks and samples the acknowledge in the middle of the high phase of the ninth bit. The capture registers and the event pulse change three clocks after SDA rises for the STOP. The bench waits twelve clocks before it reads the captures and compares the event count with its model. A pulse counter and a width monitor run on the falling clock edge, so a stray or stretched pulse is caught wherever it lands.

// File: rtl/smb_evt_port.sv
module smb_evt_port #(
  parameter logic [6:0]  OWN_ADDR    = 7'h10,
  parameter int          NUM_SHADOW  = 2,
  parameter logic [27:0] SHADOW_LIST = {7'h00, 7'h00, 7'h2C, 7'h45}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_oe,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        evt_pulse
);

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic       busy, own_hit, ack_q, evt_q, en_q;
  logic [3:0] bit_q;
  logic [2:0] byte_q;
  logic [7:0] sh_q, cmd_t, lo_t, hi_t, cap_cmd, cmp_q;
  logic [15:0] cap_data, mask_q;
  logic [3:0] sh_hit;

  wire scl     = scl_sy[1];
  wire sda     = sda_sy[1];
  wire start_c = scl & scl_d & sda_d & ~sda;
  wire stop_c  = scl & scl_d & ~sda_d & sda;
  wire rise    = scl & ~scl_d;
  wire fall    = ~scl & scl_d;

  for (genvar i = 0; i < 4; i++) begin : g_shadow
    assign sh_hit[i] = (i < NUM_SHADOW) && (sh_q[7:1] == SHADOW_LIST[7*i +: 7]);
  end

  wire own_match = sh_q[7:1] == OWN_ADDR;
  wire addr_ok   = ~sh_q[0] & (own_match | (|sh_hit));
  wire [15:0] word_t = {hi_t, lo_t};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_in};
      sda_sy <= {sda_sy[0], sda_in};
      scl_d  <= scl;
      sda_d  <= sda;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      own_hit  <= 1'b0;
      ack_q    <= 1'b0;
      evt_q    <= 1'b0;
      bit_q    <= 4'd0;
      byte_q   <= 3'd0;
      sh_q     <= 8'h00;
      cmd_t    <= 8'h00;
      lo_t     <= 8'h00;
      hi_t     <= 8'h00;
      cap_cmd  <= 8'h00;
      cap_data <= 16'h0000;
    end else begin
      evt_q <= 1'b0;
      if (start_c) begin
        busy   <= 1'b1;
        ack_q  <= 1'b0;
        bit_q  <= 4'd0;
        byte_q <= 3'd0;
      end else if (stop_c) begin
        if (busy && byte_q == 3'd4) begin
          cap_cmd  <= cmd_t;
          cap_data <= word_t;
          evt_q    <= own_hit & en_q & (cmd_t == cmp_q) & (|(mask_q & word_t));
        end
        busy  <= 1'b0;
        ack_q <= 1'b0;
      end else if (busy) begin
        if (rise && bit_q < 4'd8) begin
          sh_q  <= {sh_q[6:0], sda};
          bit_q <= bit_q + 4'd1;
        end else if (fall && ack_q) begin
          ack_q  <= 1'b0;
          bit_q  <= 4'd0;
          byte_q <= byte_q + 3'd1;
        end else if (fall && bit_q == 4'd8) begin
          if (byte_q == 3'd0) begin
            if (addr_ok) begin
              ack_q   <= 1'b1;
              own_hit <= own_match;
            end else begin
              busy <= 1'b0;
            end
          end else if (byte_q < 3'd4) begin
            ack_q <= 1'b1;
            case (byte_q)
              3'd1:    cmd_t <= sh_q;
              3'd2:    lo_t  <= sh_q;
              default: hi_t  <= sh_q;
            endcase
          end else begin
            busy <= 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= 8'h00;
      mask_q <= 16'h0000;
      en_q   <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd2:    cmp_q  <= reg_wdata[7:0];
        3'd3:    mask_q <= reg_wdata;
        3'd4:    en_q   <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {8'h00, cap_cmd};
      3'd1:    reg_rdata = cap_data;
      3'd2:    reg_rdata = {8'h00, cmp_q};
      3'd3:    reg_rdata = mask_q;
      3'd4:    reg_rdata = {15'h0000, en_q};
      default: reg_rdata = 16'h0000;
    endcase
  end

  assign sda_oe    = ack_q;
  assign evt_pulse = evt_q;

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |=> !evt_pulse);
  a_r7_cmd_equal: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> (cap_cmd == $past(cmp_q)));
  a_r8_mask_hit: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> (|(cap_data & $past(mask_q))));
  a_r9_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> $past(en_q));
  a_r2_ack_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl);

endmodule

// File: tb/smb_evt_port_tb_top.sv
`timescale 1ns/100ps
module smb_evt_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, msda = 1'b1;
  logic sda_oe, evt_pulse;
  logic [2:0] reg_addr = 3'd0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0, reg_rdata;
  wire sda_line = msda & ~sda_oe;

  int checks = 0, errors = 0, evt_cnt = 0;
  bit done = 0, evt_prev = 0;

  logic [7:0]  m_cmd = 8'h00, m_cmp = 8'h00;
  logic [15:0] m_data = 16'h0, m_mask = 16'h0;
  logic        m_en = 1'b0;

  localparam logic [6:0] OWN = 7'h10, SH0 = 7'h45, SH1 = 7'h2C;

  always #2.5 clk = ~clk;

  smb_evt_port dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .evt_pulse(evt_pulse)
  );

  always @(negedge clk) begin
    if (evt_pulse) evt_cnt++;
    if (evt_pulse && evt_prev) begin
      checks++; errors++;
      $display("FAIL R6 pulse width: act 2+ cycles exp 1");
    end
    evt_prev = evt_pulse;
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    w(1);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    w(1);
    d = reg_rdata;
  endtask

  task automatic bus_start();
    msda = 1'b1; scl = 1'b1; w(8);
    msda = 1'b0; w(8);
    scl = 1'b0; w(8);
  endtask

  task automatic bus_stop();
    msda = 1'b0; w(8);
    scl = 1'b1; w(8);
    msda = 1'b1; w(8);
  endtask

  task automatic bus_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; w(8);
      scl = 1'b1; w(8);
      scl = 1'b0; w(8);
    end
    msda = 1'b1; w(8);
    scl = 1'b1; w(4);
    ack = sda_line; w(4);
    scl = 1'b0; w(8);
  endtask

  function automatic bit is_match(input logic [6:0] a);
    return a == OWN || a == SH0 || a == SH1;
  endfunction

  function automatic bit exp_evt(input logic [6:0] a, input logic [7:0] c, input logic [15:0] d);
    return a == OWN && m_en && c == m_cmp && (|(m_mask & d));
  endfunction

  task automatic xfer(input string req, input logic [6:0] a, input logic rw, input int nb,
                      input logic [7:0] c, input logic [15:0] d);
    logic ack;
    logic [15:0] rd;
    int e0;
    bit acked, ev;
    e0 = evt_cnt;
    acked = is_match(a) && !rw;
    ev = acked && nb == 3 && exp_evt(a, c, d);
    bus_start();
    bus_byte({a, rw}, ack);
    chk({req, " R2/R3 address ack"}, {15'h0, ack}, {15'h0, !acked});
    if (acked) begin
      if (nb > 0) begin bus_byte(c, ack);       chk({req, " R2 cmd ack"}, {15'h0, ack}, 16'h0); end
      if (nb > 1) begin bus_byte(d[7:0], ack);  chk({req, " R2 lo ack"},  {15'h0, ack}, 16'h0); end
      if (nb > 2) begin bus_byte(d[15:8], ack); chk({req, " R2 hi ack"},  {15'h0, ack}, 16'h0); end
    end
    bus_stop();
    w(12);
    if (acked && nb == 3) begin m_cmd = c; m_data = d; end
    reg_read(3'd0, rd); chk({req, " R4 captured cmd"}, rd, {8'h0, m_cmd});
    reg_read(3'd1, rd); chk({req, " R4 captured data"}, rd, m_data);
    chk({req, " R6 event count"}, 16'(evt_cnt - e0), {15'h0, ev});
  endtask

  task automatic cfg(input logic [7:0] c, input logic [15:0] m, input logic e);
    logic [15:0] rd;
    reg_write(3'd2, {8'hA5, c}); m_cmp = c;
    reg_write(3'd3, m); m_mask = m;
    reg_write(3'd4, {15'h7FFF, e}); m_en = e;
    reg_read(3'd2, rd); chk("R11 compare readback", rd, {8'h0, c});
    reg_read(3'd3, rd); chk("R11 mask readback", rd, m);
    reg_read(3'd4, rd); chk("R11 enable readback", rd, {15'h0, e});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    void'($urandom(32'd20240611));
    w(4);
    rst_n = 1'b1;
    w(2);
    for (int a = 0; a < 5; a++) begin
      reg_read(3'(a), rd);
      chk("R1 reset register", rd, 16'h0);
    end
    chk("R1 reset outputs", {14'h0, sda_oe, evt_pulse}, 16'h0);

    reg_addr = 3'd3; reg_wdata = 16'h1234; reg_wr = 1'b1;
    chk("R11 write not yet visible", reg_rdata, 16'h0);
    w(1); reg_wr = 1'b0;
    chk("R11 write visible next clock", reg_rdata, 16'h1234);

    cfg(8'h3C, 16'h00F0, 1'b1);
    xfer("R6 hit", OWN, 1'b0, 3, 8'h3C, 16'h0010);
    xfer("R4 byte order", OWN, 1'b0, 3, 8'h3C, 16'hAB01);
    xfer("R7 cmd miss", OWN, 1'b0, 3, 8'h3D, 16'h00F0);
    xfer("R8 mask miss", OWN, 1'b0, 3, 8'h3C, 16'hFF0F);
    xfer("R5 shadow0", SH0, 1'b0, 3, 8'h3C, 16'h00F0);
    xfer("R5 shadow1", SH1, 1'b0, 3, 8'h3C, 16'h0080);
    xfer("R3 other addr", 7'h11, 1'b0, 3, 8'h3C, 16'h00F0);
    xfer("R3 read own", OWN, 1'b1, 3, 8'h3C, 16'h00F0);
    xfer("R10 short", OWN, 1'b0, 2, 8'h3C, 16'h00F0);
    cfg(8'h3C, 16'h00F0, 1'b0);
    xfer("R9 disabled", OWN, 1'b0, 3, 8'h3C, 16'h0030);
    cfg(8'h3C, 16'h00F0, 1'b1);
    xfer("R6 re-enabled", OWN, 1'b0, 3, 8'h3C, 16'h8020);

    for (int it = 0; it < 36; it++) begin
      logic [6:0] a;
      logic [7:0] c;
      int k;
      if (it % 8 == 0)
        cfg(8'($urandom), 16'($urandom) & 16'($urandom), ($urandom % 4) != 0);
      k = $urandom % 5;
      case (k)
        0, 1: a = OWN;
        2: a = SH0;
        3: a = SH1;
        default: begin
          a = 7'($urandom);
          while (is_match(a)) a = 7'($urandom);
        end
      endcase
      c = ($urandom % 2) ? m_cmp : 8'($urandom);
      xfer("R6 random", a, 1'b0, 3, c, 16'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule